// File: doc/BRIEF.md
# Bridge Fault Supervisor with Tachometer

This block watches the digital protection flags of a three-phase gate driver and decides when the power bridge must coast. Each flag arrives as a clean comparator output already synchronised to the clock. The flags cover high-side gate-source droop, bootstrap charge current still high, phase node still high, motor-lead short, supply undervoltage, over-temperature and an illegal Hall code. The block tolerates a limited number of high-side gate droops in each commutation by asking for a recharge cycle. It runs a watchdog over each bootstrap charging interval. It latches every other fault until the driver is disabled.

The commutation logic feeds the block a one-cycle Hall edge strobe and tells it whether a high-side or a low-side switch is currently on. Each Hall edge starts a fixed-width tachometer pulse. It also clears the droop count and the droop and bootstrap faults, unless the motor has stalled. A stall is recognised when a fault stays latched without any Hall edge for a set time. From then on, only the disable input clears the fault. All timers are cycle counts computed from the clock frequency and the time parameters.

Top module: `drive_fault_supervisor`

## Requirements
- R1: After reset, with the disable, undervoltage and fault flags low, coast, fault, rchg_req and tach are all 0.
- R2: fault is 1 whenever any fault is latched or uv is 1, and coast is 1 whenever fault is 1 or drv_disable is 1. uv is not latched: coast and fault fall in the same cycle uv falls, provided nothing is latched.
- R3: A droop event is sampled at a clock edge where hs_on and gs_low are both 1, no recharge is pending and the bridge is not coasting. In the cycle after it, rchg_req rises to 1. rchg_req stays 1 until an edge samples gs_low at 0, and falls in the cycle after that edge. rchg_req is 0 whenever coast is 1.
- R4: The DROOP_LIMIT-th droop event (default 3) within one commutation latches a droop fault in the cycle after its edge. A Hall edge resets the count, so droops split across commutations never latch.
- R5: The bootstrap watchdog counts consecutive edges with ls_on at 1, starting from 1. On the edge numbered WDOG_US*CLK_MHZ, if chg_hi or node_hi is 1, a bootstrap fault latches. It latches in no other case, and it also does not latch when ls_on drops before that edge.
- R6: lead_short latches a fault only when it is sampled together with hs_on at 1. With hs_on at 0 it is ignored.
- R7: ot_flag or hall_bad sampled at 1 latches a fault that stays after the flag returns to 0.
- R8: A Hall edge clears the droop and bootstrap faults when there is no stall. Lead, thermal and Hall faults survive Hall edges.
- R9: Once a fault has been latched for STALL_US*CLK_MHZ consecutive cycles with no Hall edge, Hall edges no longer clear any fault.
- R10: drv_disable at 1 forces coast. At the next edge it clears all latched faults, counts and the stall state.
- R11: tach goes to 1 in the cycle after a sampled hall_edge and stays 1 for exactly TACH_US*CLK_MHZ cycles. A new edge restarts the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_disable | input | 1 | Disable: forces coast, clears latched faults |
| hall_edge | input | 1 | One-cycle strobe at every Hall transition |
| hall_bad | input | 1 | Hall inputs show an illegal code |
| hs_on | input | 1 | A high-side switch is commanded on |
| ls_on | input | 1 | A low-side switch is on (bootstrap charging) |
| gs_low | input | 1 | High-side gate-source voltage below threshold |
| chg_hi | input | 1 | Bootstrap charge current still high |
| node_hi | input | 1 | Phase node still high during charging |
| lead_short | input | 1 | Motor lead short comparator |
| uv | input | 1 | Supply undervoltage |
| ot_flag | input | 1 | Over-temperature |
| coast | output | 1 | All power switches must be off |
| fault | output | 1 | Fault indication |
| rchg_req | output | 1 | High side off, low side on to recharge |
| tach | output | 1 | Tachometer pulse |

## Verification
The droop path is driven by a seeded random stream of gs_low levels and sparse Hall edges with the high side held on, and a bench model predicts the outcome. This stream tells apart droop counting, the end of a recharge, trips at the limit and clearing at the commutation edge. The same stream checks tach width and retriggering against an independent counter. Directed cases cover the boundaries: the watchdog sampled one edge before and exactly at expiry, with either charging flag and with an early ls_on drop. They also place lead_short with and without hs_on, and they separate sticky faults from faults a commutation edge clears. A last case holds a fault past the stall time and shows that a Hall edge then no longer clears it, while drv_disable still does.

// File: rtl/dfs_pkg.sv
// Package: shared fault vector type and a time-to-cycles helper.
// Assumes time parameters are whole microseconds and clock in MHz.
package dfs_pkg;

    // One bit per latched fault cause
    typedef struct packed {
        logic gate_droop;
        logic boot_chg;
        logic lead;
        logic thermal;
        logic hall;
    } flt_t;

    // Converts microseconds to clock cycles
    function automatic int unsigned us_to_cyc(input int unsigned us, input int unsigned mhz);
        return us * mhz;
    endfunction

endpackage

// File: rtl/gs_droop_ctrl.sv
// Gate-source droop controller: counts high-side droop events within a
// commutation and requests recharge after each one; reports a trip on the
// DROOP_LIMIT-th event. Assumes clr is the commutation/disable strobe.
module gs_droop_ctrl #(
    parameter int unsigned DROOP_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic hs_on,
    input  logic gs_low,
    output logic rchg_q,
    output logic trip
);
    localparam int unsigned CW = $clog2(DROOP_LIMIT + 1);

    logic [CW-1:0] cnt_q;
    logic          event_w;

    assign event_w = en && !clr && hs_on && gs_low && !rchg_q;
    assign trip    = event_w && (cnt_q == CW'(DROOP_LIMIT - 1));

    // Droop count and pending-recharge state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rchg_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            rchg_q <= 1'b0;
        end else if (!en) begin
            rchg_q <= 1'b0;
        end else if (event_w) begin
            if (cnt_q != CW'(DROOP_LIMIT)) cnt_q <= cnt_q + 1'b1;
            rchg_q <= 1'b1;
        end else if (rchg_q && !gs_low) begin
            rchg_q <= 1'b0;
        end
    end
endmodule

// File: rtl/boot_watchdog.sv
// Bootstrap charge watchdog: counts edges with the low side on and, at the
// WDOG_CYC-th one, trips if charge current or node level is still high.
// Assumes ls_on stays high for the whole charging interval.
module boot_watchdog #(
    parameter int unsigned WDOG_CYC = 34000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    input  logic ls_on,
    input  logic chg_hi,
    input  logic node_hi,
    output logic trip
);
    localparam int unsigned CW = $clog2(WDOG_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign trip = en && !restart && ls_on && (chg_hi || node_hi)
                  && (cnt_q == CW'(WDOG_CYC - 1));

    // Saturating charging-time counter
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !ls_on) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(WDOG_CYC)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tach_pulse.sv
// Tachometer pulse: fixed-width pulse restarted by every Hall edge.
// Assumes hall_edge is a single-cycle strobe.
module tach_pulse #(
    parameter int unsigned TACH_CYC = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_edge,
    output logic tach
);
    localparam int unsigned CW = $clog2(TACH_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign tach = (cnt_q != '0);

    // Remaining pulse length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (hall_edge) begin
            cnt_q <= CW'(TACH_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/fault_keeper.sv
// Fault latch bank with stall detection. Droop and bootstrap faults clear
// on a Hall edge unless a stall was seen; all clear on disable.
// Assumes set bits are already qualified by their conditions.
module fault_keeper
    import dfs_pkg::*;
#(
    parameter int unsigned STALL_CYC = 10000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_disable,
    input  logic hall_edge,
    input  flt_t set,
    output flt_t flt_q,
    output logic stalled_q
);
    localparam int unsigned CW = $clog2(STALL_CYC + 1);

    logic [CW-1:0] scnt_q;
    logic          commut_clr;

    assign commut_clr = hall_edge && !stalled_q;

    // Latched fault causes
    always_ff @(posedge clk) begin
        if (!rst_n || drv_disable) begin
            flt_q <= '0;
        end else begin
            flt_q.gate_droop <= (flt_q.gate_droop && !commut_clr) || set.gate_droop;
            flt_q.boot_chg   <= (flt_q.boot_chg && !commut_clr) || set.boot_chg;
            flt_q.lead       <= flt_q.lead || set.lead;
            flt_q.thermal    <= flt_q.thermal || set.thermal;
            flt_q.hall       <= flt_q.hall || set.hall;
        end
    end

    // Time without Hall edges while a fault is held
    always_ff @(posedge clk) begin
        if (!rst_n || drv_disable) begin
            scnt_q    <= '0;
            stalled_q <= 1'b0;
        end else if (hall_edge || (flt_q == '0)) begin
            scnt_q <= '0;
        end else if (scnt_q == CW'(STALL_CYC - 1)) begin
            stalled_q <= 1'b1;
        end else begin
            scnt_q <= scnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/drive_fault_supervisor.sv
// Top: joins droop control, bootstrap watchdog, fault bank and tachometer;
// derives coast, fault and the recharge request.
// Assumes all inputs are synchronous to clk.
module drive_fault_supervisor
    import dfs_pkg::*;
#(
    parameter int unsigned CLK_MHZ     = 200,
    parameter int unsigned WDOG_US     = 170,
    parameter int unsigned TACH_US     = 3,
    parameter int unsigned STALL_US    = 50000,
    parameter int unsigned DROOP_LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_disable,
    input  logic hall_edge,
    input  logic hall_bad,
    input  logic hs_on,
    input  logic ls_on,
    input  logic gs_low,
    input  logic chg_hi,
    input  logic node_hi,
    input  logic lead_short,
    input  logic uv,
    input  logic ot_flag,
    output logic coast,
    output logic fault,
    output logic rchg_req,
    output logic tach
);
    localparam int unsigned WDOG_CYC  = us_to_cyc(WDOG_US, CLK_MHZ);
    localparam int unsigned TACH_CYC  = us_to_cyc(TACH_US, CLK_MHZ);
    localparam int unsigned STALL_CYC = us_to_cyc(STALL_US, CLK_MHZ);

    flt_t flt_q;
    flt_t set;
    logic stalled_q;
    logic rchg_q;
    logic droop_trip;
    logic boot_trip;
    logic run_en;
    logic any_flt;

    assign any_flt = |flt_q;
    assign fault   = any_flt || uv;
    assign coast   = fault || drv_disable;
    assign run_en  = !coast;

    assign set.gate_droop = droop_trip;
    assign set.boot_chg   = boot_trip;
    assign set.lead       = lead_short && hs_on;
    assign set.thermal    = ot_flag;
    assign set.hall       = hall_bad;

    assign rchg_req = rchg_q && !coast;

    gs_droop_ctrl #(.DROOP_LIMIT(DROOP_LIMIT)) u_droop (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run_en),
        .clr    (hall_edge || drv_disable),
        .hs_on  (hs_on),
        .gs_low (gs_low),
        .rchg_q (rchg_q),
        .trip   (droop_trip)
    );

    boot_watchdog #(.WDOG_CYC(WDOG_CYC)) u_boot (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (run_en),
        .restart (hall_edge || drv_disable),
        .ls_on   (ls_on),
        .chg_hi  (chg_hi),
        .node_hi (node_hi),
        .trip    (boot_trip)
    );

    fault_keeper #(.STALL_CYC(STALL_CYC)) u_keep (
        .clk         (clk),
        .rst_n       (rst_n),
        .drv_disable (drv_disable),
        .hall_edge   (hall_edge),
        .set         (set),
        .flt_q       (flt_q),
        .stalled_q   (stalled_q)
    );

    tach_pulse #(.TACH_CYC(TACH_CYC)) u_tach (
        .clk       (clk),
        .rst_n     (rst_n),
        .hall_edge (hall_edge),
        .tach      (tach)
    );
endmodule

// File: rtl/dfs_checker.sv
// Checker: port-level properties of the supervisor, bound to the top.
module dfs_checker (
    input logic clk,
    input logic rst_n,
    input logic drv_disable,
    input logic hall_edge,
    input logic hs_on,
    input logic gs_low,
    input logic uv,
    input logic coast,
    input logic fault,
    input logic rchg_req,
    input logic tach
);
    AST_FAULT_COAST: assert property (@(posedge clk) disable iff (!rst_n) fault |-> coast); // R2
    AST_UV_FAULT: assert property (@(posedge clk) disable iff (!rst_n) uv |-> (fault && coast)); // R2
    AST_RCHG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rchg_req) |-> $past(hs_on && gs_low)); // R3
    AST_RCHG_NOT_COAST: assert property (@(posedge clk) disable iff (!rst_n) coast |-> !rchg_req); // R3
    AST_DISABLE_COAST: assert property (@(posedge clk) disable iff (!rst_n) drv_disable |-> coast); // R10
    AST_TACH_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(tach) |-> $past(hall_edge)); // R11
endmodule

bind drive_fault_supervisor dfs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_disable (drv_disable),
    .hall_edge   (hall_edge),
    .hs_on       (hs_on),
    .gs_low      (gs_low),
    .uv          (uv),
    .coast       (coast),
    .fault       (fault),
    .rchg_req    (rchg_req),
    .tach        (tach)
);

// File: tb/sim_drive_fault_supervisor.sv
// Bench: directed corner cases plus a seeded random droop/Hall stream.
module sim_drive_fault_supervisor;
    localparam int unsigned MHZ   = 4;
    localparam int unsigned WDOG  = 170 * MHZ;
    localparam int unsigned TACHW = 3 * MHZ;
    localparam int unsigned STALL = 100 * MHZ;
    localparam int unsigned LIM   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drv_disable = 1'b0, hall_edge = 1'b0, hall_bad = 1'b0, hs_on = 1'b0;
    logic ls_on = 1'b0, gs_low = 1'b0, chg_hi = 1'b0, node_hi = 1'b0;
    logic lead_short = 1'b0, uv = 1'b0, ot_flag = 1'b0;
    logic coast, fault, rchg_req, tach;
    int   n_chk = 0;
    int   n_fail = 0;

    always #2.5 clk = ~clk;

    drive_fault_supervisor #(
        .CLK_MHZ(MHZ), .WDOG_US(170), .TACH_US(3), .STALL_US(100), .DROOP_LIMIT(LIM)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .drv_disable(drv_disable), .hall_edge(hall_edge),
        .hall_bad(hall_bad), .hs_on(hs_on), .ls_on(ls_on), .gs_low(gs_low),
        .chg_hi(chg_hi), .node_hi(node_hi), .lead_short(lead_short), .uv(uv),
        .ot_flag(ot_flag), .coast(coast), .fault(fault), .rchg_req(rchg_req), .tach(tach)
    );

    // Compare one output bit against its expected value
    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance n edges and sample 1 ns after the last
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic hall_pulse();
        hall_edge = 1'b1; step(1); hall_edge = 1'b0;
    endtask

    task automatic disable_pulse();
        drv_disable = 1'b1; step(1); drv_disable = 1'b0; step(1);
    endtask

    // One droop: raise gs_low for one edge, then release it
    task automatic droop();
        gs_low = 1'b1; step(1); gs_low = 1'b0; step(1);
    endtask

    // Expected tach level from the bench's own pulse counter
    function automatic int tach_next(input int cnt, input logic he);
        if (he) return TACHW;
        return (cnt > 0) ? cnt - 1 : 0;
    endfunction

    initial begin
        #(5ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int m_cnt, m_tach, seed;
        logic m_rchg, m_flt;
        seed = 32'h5eed;
        void'($urandom(seed));

        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1", "coast", coast, 1'b0);
        chk("R1", "fault", fault, 1'b0);
        chk("R1", "rchg_req", rchg_req, 1'b0);
        chk("R1", "tach", tach, 1'b0);

        // R2 undervoltage is not latched
        uv = 1'b1; step(1);
        chk("R2", "coast under uv", coast, 1'b1);
        chk("R2", "fault under uv", fault, 1'b1);
        uv = 1'b0; step(1);
        chk("R2", "coast after uv", coast, 1'b0);

        // R3 recharge request and release
        hs_on = 1'b1;
        gs_low = 1'b1; step(1);
        chk("R3", "rchg after droop", rchg_req, 1'b1);
        step(1);
        chk("R3", "rchg held", rchg_req, 1'b1);
        gs_low = 1'b0; step(1);
        chk("R3", "rchg released", rchg_req, 1'b0);
        // R4 second droop ok, third trips
        droop();
        chk("R4", "fault after two", fault, 1'b0);
        gs_low = 1'b1; step(1); gs_low = 1'b0;
        chk("R4", "fault at limit", fault, 1'b1);
        chk("R2", "coast with fault", coast, 1'b1);
        chk("R3", "rchg masked in coast", rchg_req, 1'b0);
        // R8 Hall edge clears droop fault
        hall_pulse();
        chk("R8", "droop fault cleared", fault, 1'b0);
        // R4 count reset across commutation
        droop(); droop(); hall_pulse(); droop(); droop();
        chk("R4", "split droops", fault, 1'b0);
        hall_pulse();
        hs_on = 1'b0;

        // R5 bootstrap watchdog expiry with chg_hi
        ls_on = 1'b1; chg_hi = 1'b1;
        step(WDOG - 1);
        chk("R5", "before expiry", fault, 1'b0);
        step(1);
        chk("R5", "at expiry chg_hi", fault, 1'b1);
        ls_on = 1'b0; chg_hi = 1'b0; hall_pulse();
        chk("R8", "boot fault cleared", fault, 1'b0);
        // R5 node_hi alone
        ls_on = 1'b1; node_hi = 1'b1; step(WDOG);
        chk("R5", "at expiry node_hi", fault, 1'b1);
        ls_on = 1'b0; node_hi = 1'b0; hall_pulse();
        // R5 flags low at expiry
        ls_on = 1'b1; step(WDOG + 3);
        chk("R5", "clean charge", fault, 1'b0);
        ls_on = 1'b0; step(1);
        // R5 ls_on drops early
        ls_on = 1'b1; step(WDOG - 2);
        ls_on = 1'b0; chg_hi = 1'b1; step(5);
        chk("R5", "early drop", fault, 1'b0);
        chg_hi = 1'b0;

        // R6 lead short qualified by high side
        lead_short = 1'b1; step(1);
        chk("R6", "lead without hs", fault, 1'b0);
        hs_on = 1'b1; step(1); lead_short = 1'b0; hs_on = 1'b0;
        chk("R6", "lead with hs", fault, 1'b1);
        hall_pulse();
        chk("R8", "lead survives hall", fault, 1'b1);
        // R10 disable clears
        drv_disable = 1'b1; step(1);
        chk("R10", "coast on disable", coast, 1'b1);
        drv_disable = 1'b0; step(1);
        chk("R10", "cleared by disable", fault, 1'b0);

        // R7 sticky thermal and hall faults
        ot_flag = 1'b1; step(1); ot_flag = 1'b0; step(5);
        chk("R7", "thermal sticky", fault, 1'b1);
        hall_pulse();
        chk("R8", "thermal survives hall", fault, 1'b1);
        disable_pulse();
        hall_bad = 1'b1; step(1); hall_bad = 1'b0; step(5);
        chk("R7", "hall code sticky", fault, 1'b1);
        disable_pulse();
        chk("R10", "hall fault cleared", fault, 1'b0);

        // R9 stall blocks commutation clearing
        hs_on = 1'b1; droop(); droop(); droop(); hs_on = 1'b0;
        chk("R9", "droop fault set", fault, 1'b1);
        step(STALL + 5);
        hall_pulse();
        chk("R9", "stalled not cleared", fault, 1'b1);
        disable_pulse();
        chk("R9", "disable clears stall", fault, 1'b0);
        step(TACHW + 2);

        // R11 tach exact width
        hall_pulse();
        chk("R11", "tach rises", tach, 1'b1);
        step(TACHW - 1);
        chk("R11", "tach last cycle", tach, 1'b1);
        step(1);
        chk("R11", "tach ends", tach, 1'b0);

        // R3 R4 R8 R11 random droop/Hall stream against bench model
        m_cnt = 0; m_rchg = 1'b0; m_flt = 1'b0; m_tach = 0;
        hs_on = 1'b1;
        for (int i = 0; i < 2000; i++) begin
            gs_low    = ($urandom % 2) == 0;
            hall_edge = ($urandom % 15) == 0;
            if (hall_edge) begin
                m_cnt = 0; m_rchg = 1'b0; m_flt = 1'b0;
            end else if (m_flt) begin
                m_rchg = 1'b0;
            end else if (gs_low && !m_rchg) begin
                if (m_cnt == LIM - 1) m_flt = 1'b1;
                if (m_cnt < LIM) m_cnt++;
                m_rchg = 1'b1;
            end else if (m_rchg && !gs_low) begin
                m_rchg = 1'b0;
            end
            m_tach = tach_next(m_tach, hall_edge);
            step(1);
            chk("R4", "random fault", fault, m_flt);
            chk("R3", "random rchg", rchg_req, m_rchg && !m_flt);
            chk("R11", "random tach", tach, m_tach != 0);
        end
        hall_edge = 1'b0; hs_on = 1'b0; gs_low = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule